// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a small 8-bit microcontroller core and puts it to sleep when software asks. Two request bits are written through a write strobe: one asks for a light sleep in which only the CPU clock is gated while RAM, timers, the serial unit and interrupt logic keep running; the other asks for a deep sleep in which the oscillator enable drops and every register and RAM cell holds its value. The written bits can be read back on two outputs and clear by themselves when the core wakes.

While asleep the block forces the bus-control strobes and tells each of the four port drivers what to show. The choice depends on the sleep depth and on whether code is fetched from on-chip or off-chip program memory. Light sleep ends on any enabled interrupt request or on an external interrupt. Deep sleep ends only on an external interrupt. A hardware reset ends either.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the controller is awake. Both request bits read 0. `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `ctl_ovr` is 0 and every port field of `port_mode` is 0 (normal).
- R2: A write with `req_idle`=1 sets `idle_bit` at that clock edge. At the following edge `cpu_clk_en` falls while `per_clk_en` and `osc_en` stay 1.
- R3: A write with `req_pdown`=1 sets `pdown_bit`. At the following edge `cpu_clk_en`, `per_clk_en` and `osc_en` all fall to 0.
- R4: A write with both request inputs at 1 sets only `pdown_bit` and leads to deep sleep.
- R5: In light sleep, any bit of `int_req` or `ext_int` returns the block to awake at the next edge and clears `idle_bit` at that same edge.
- R6: In deep sleep, `int_req` has no effect. Only a bit of `ext_int` wakes the block, and that edge also clears `pdown_bit`.
- R7: While asleep `ctl_ovr` is 1. `ctl_lvl` is 1 in light sleep and 0 in deep sleep.
- R8: With `ext_access`=0, every port field reads 1 (hold latched data) in both sleep modes. Port k occupies `port_mode[2k+1:2k]`. The codes are 0 normal, 1 hold data, 2 float, 3 address.
- R9: With `ext_access`=1, port 0 reads 2 (float) in both sleep modes. Port 2 reads 3 (address) in light sleep and 1 in deep sleep. Ports 1 and 3 read 1.
- R10: A write strobe while asleep is ignored, and the request bits keep their values.
- R11: Asserting `rst_n` low in either sleep mode returns all outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_wr | input | 1 | Write strobe for the request bits |
| req_idle | input | 1 | Light-sleep request value |
| req_pdown | input | 1 | Deep-sleep request value |
| int_req | input | N_INT | Enabled interrupt requests, already masked |
| ext_int | input | N_EXT | External interrupt requests |
| ext_access | input | 1 | 1 = code runs from off-chip program memory |
| idle_bit | output | 1 | Light-sleep request bit readback |
| pdown_bit | output | 1 | Deep-sleep request bit readback |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral, RAM and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| ctl_ovr | output | 1 | Forces the address-latch and program-store strobes |
| ctl_lvl | output | 1 | Level for the forced strobes |
| port_mode | output | 2*N_PORT | Per-port sleep behaviour code |

## Verification
The properties assume that software writes the request bits only while the core is awake and no earlier request is pending. They also assume `clk` keeps running in deep sleep, so wake requests can be sampled. The stimulus follows these rules: every write is made from the awake state and is followed by idle cycles before the next write. Interrupts are raised only between writes. One write is deliberately made while asleep, to show that it is ignored.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    LPM_RUN   = 2'd0,
    LPM_IDLE  = 2'd1,
    LPM_PDOWN = 2'd2
  } lpm_state_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_HOLD   = 2'd1,
    PM_FLOAT  = 2'd2,
    PM_ADDR   = 2'd3
  } port_mode_e;

  // Wake rule: light sleep accepts any request, deep sleep only external ones.
  function automatic logic wake_ok(lpm_state_e st, logic any_int, logic any_ext);
    case (st)
      LPM_IDLE:  wake_ok = any_int | any_ext;
      LPM_PDOWN: wake_ok = any_ext;
      default:   wake_ok = 1'b0;
    endcase
  endfunction

  // Port behaviour in sleep.
  function automatic port_mode_e port_code(lpm_state_e st, logic ext,
                                           logic is_lo, logic is_hi);
    if (st == LPM_RUN)                    port_code = PM_NORMAL;
    else if (!ext)                        port_code = PM_HOLD;
    else if (is_lo)                       port_code = PM_FLOAT;
    else if (is_hi && st == LPM_IDLE)     port_code = PM_ADDR;
    else                                  port_code = PM_HOLD;
  endfunction

endpackage

// File: rtl/lpm_wake_det.sv
module lpm_wake_det #(
  parameter int N_INT = 5,
  parameter int N_EXT = 2
) (
  input  lpm_pkg::lpm_state_e st,
  input  logic [N_INT-1:0]    int_req,
  input  logic [N_EXT-1:0]    ext_int,
  output logic                wake_evt
);
  import lpm_pkg::*;
  logic any_int, any_ext;
  assign any_int  = |int_req;
  assign any_ext  = |ext_int;
  assign wake_evt = wake_ok(st, any_int, any_ext);
endmodule

// File: rtl/lpm_req_reg.sv
module lpm_req_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic wr,
  input  logic want_idle,
  input  logic want_pdown,
  input  logic clr,
  output logic idle_q,
  output logic pdown_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      pdown_q <= 1'b0;
    end else if (clr) begin
      idle_q  <= 1'b0;
      pdown_q <= 1'b0;
    end else if (wr && accept) begin
      pdown_q <= want_pdown;
      idle_q  <= want_idle & ~want_pdown;
    end
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle_q,
  input  logic                pdown_q,
  input  logic                wake_evt,
  output lpm_pkg::lpm_state_e st
);
  import lpm_pkg::*;
  lpm_state_e st_d;

  always_comb begin
    st_d = st;
    case (st)
      LPM_RUN: begin
        if (pdown_q)     st_d = LPM_PDOWN;
        else if (idle_q) st_d = LPM_IDLE;
      end
      LPM_IDLE, LPM_PDOWN: if (wake_evt) st_d = LPM_RUN;
      default: st_d = LPM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= LPM_RUN;
    else        st <= st_d;
  end
endmodule

// File: rtl/lpm_pin_map.sv
module lpm_pin_map #(
  parameter int N_PORT  = 4,
  parameter int LO_PORT = 0,
  parameter int HI_PORT = 2
) (
  input  lpm_pkg::lpm_state_e  st,
  input  logic                 ext_access,
  output logic                 ctl_ovr,
  output logic                 ctl_lvl,
  output logic [2*N_PORT-1:0]  port_mode
);
  import lpm_pkg::*;
  assign ctl_ovr = (st != LPM_RUN);
  assign ctl_lvl = (st == LPM_IDLE);

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    localparam logic IS_LO = (g == LO_PORT);
    localparam logic IS_HI = (g == HI_PORT);
    assign port_mode[2*g +: 2] = port_code(st, ext_access, IS_LO, IS_HI);
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int N_INT  = 5,
  parameter int N_EXT  = 2,
  parameter int N_PORT = 4,
  localparam int PM_W  = 2 * N_PORT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic             req_idle,
  input  logic             req_pdown,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_EXT-1:0] ext_int,
  input  logic             ext_access,
  output logic             idle_bit,
  output logic             pdown_bit,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             ctl_ovr,
  output logic             ctl_lvl,
  output logic [PM_W-1:0]  port_mode
);
  import lpm_pkg::*;

  lpm_state_e st;
  logic       wake_evt;
  logic       accept;

  assign accept = (st == LPM_RUN);

  lpm_wake_det #(.N_INT(N_INT), .N_EXT(N_EXT)) u_wake (
    .st(st), .int_req(int_req), .ext_int(ext_int), .wake_evt(wake_evt)
  );

  lpm_req_reg u_req (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr(req_wr),
    .want_idle(req_idle), .want_pdown(req_pdown), .clr(wake_evt),
    .idle_q(idle_bit), .pdown_q(pdown_bit)
  );

  lpm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .idle_q(idle_bit), .pdown_q(pdown_bit),
    .wake_evt(wake_evt), .st(st)
  );

  lpm_pin_map #(.N_PORT(N_PORT), .LO_PORT(0), .HI_PORT(2)) u_pins (
    .st(st), .ext_access(ext_access), .ctl_ovr(ctl_ovr),
    .ctl_lvl(ctl_lvl), .port_mode(port_mode)
  );

  assign cpu_clk_en = (st == LPM_RUN);
  assign per_clk_en = (st != LPM_PDOWN);
  assign osc_en     = (st != LPM_PDOWN);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int N_INT  = 5,
  parameter int N_EXT  = 2,
  parameter int N_PORT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_wr,
  input logic [N_INT-1:0]  int_req,
  input logic [N_EXT-1:0]  ext_int,
  input logic              ext_access,
  input logic              idle_bit,
  input logic              pdown_bit,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              osc_en,
  input logic              ctl_ovr,
  input logic              ctl_lvl,
  input logic [2*N_PORT-1:0] port_mode
);
  logic light, deep;
  assign light = !cpu_clk_en && osc_en;
  assign deep  = !osc_en;

  p_enter_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_bit && cpu_clk_en) |=> !cpu_clk_en);
  p_idle_keeps_per_r2: assert property (@(posedge clk) disable iff (!rst_n)
    light |-> per_clk_en);
  p_pd_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deep |-> (!per_clk_en && !cpu_clk_en));
  p_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_bit && pdown_bit));
  p_idle_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (light && ((|int_req) || (|ext_int))) |=> (cpu_clk_en && !idle_bit));
  p_pd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deep && !(|ext_int)) |=> deep);
  p_pd_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deep && (|ext_int)) |=> (osc_en && !pdown_bit));
  p_strobe_lvl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ovr |-> (ctl_lvl == osc_en));
  p_int_ports_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ovr && !ext_access) |-> (port_mode == {N_PORT{2'b01}}));
  p_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && req_wr && !(|ext_int) && !(|int_req))
      |=> ($stable(idle_bit) && $stable(pdown_bit)));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_INT(N_INT), .N_EXT(N_EXT), .N_PORT(N_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .int_req(int_req),
  .ext_int(ext_int), .ext_access(ext_access), .idle_bit(idle_bit),
  .pdown_bit(pdown_bit), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .osc_en(osc_en), .ctl_ovr(ctl_ovr), .ctl_lvl(ctl_lvl), .port_mode(port_mode)
);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
  localparam int NI = 5;
  localparam int NE = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, req_wr = 1'b0, req_idle = 1'b0, req_pdown = 1'b0;
  logic [NI-1:0] int_req = '0;
  logic [NE-1:0] ext_int = '0;
  logic ext_access = 1'b0;
  logic idle_bit, pdown_bit, cpu_clk_en, per_clk_en, osc_en, ctl_ovr, ctl_lvl;
  logic [7:0] port_mode;

  lpm_ctrl #(.N_INT(NI), .N_EXT(NE), .N_PORT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_idle(req_idle),
    .req_pdown(req_pdown), .int_req(int_req), .ext_int(ext_int),
    .ext_access(ext_access), .idle_bit(idle_bit), .pdown_bit(pdown_bit),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .ctl_ovr(ctl_ovr), .ctl_lvl(ctl_lvl), .port_mode(port_mode)
  );

  typedef struct packed {
    logic ib, pb, cpu, per, osc, ovr, lvl;
    logic [7:0] pm;
  } obs_t;

  obs_t exp_q[$];
  int   rid_q[$];
  int   checks = 0;
  int   errors = 0;

  // Bench view of the block: 0 awake, 1 light sleep, 2 deep sleep.
  int   m_st = 0;
  logic m_ib = 1'b0, m_pb = 1'b0;

  function automatic obs_t predict();
    obs_t o;
    o.ib  = m_ib;
    o.pb  = m_pb;
    o.cpu = (m_st == 0);
    o.per = (m_st != 2);
    o.osc = (m_st != 2);
    o.ovr = (m_st != 0);
    o.lvl = (m_st == 1);
    // fields: port3 port2 port1 port0 ; 1 hold, 2 float, 3 address
    if (m_st == 0)        o.pm = 8'b00_00_00_00;
    else if (!ext_access) o.pm = 8'b01_01_01_01;
    else if (m_st == 1)   o.pm = 8'b01_11_01_10;
    else                  o.pm = 8'b01_01_01_10;
    return o;
  endfunction

  task automatic push(input int r);
    exp_q.push_back(predict());
    rid_q.push_back(r);
  endtask

  // One clock of stimulus, then the expectation after that edge.
  task automatic cyc(input logic wr, input logic wi, input logic wp,
                     input logic [NI-1:0] ir, input logic [NE-1:0] ei,
                     input int r);
    @(negedge clk); #1;
    req_wr = wr; req_idle = wi; req_pdown = wp; int_req = ir; ext_int = ei;
    @(posedge clk);
    case (m_st)
      0: begin
        m_st = m_pb ? 2 : (m_ib ? 1 : 0);
        if (wr) begin m_pb = wp; m_ib = wi && !wp; end
      end
      1: if ((|ir) || (|ei)) begin m_st = 0; m_ib = 1'b0; m_pb = 1'b0; end
      default: if (|ei) begin m_st = 0; m_ib = 1'b0; m_pb = 1'b0; end
    endcase
    #1;
    push(r);
  endtask

  task automatic hw_reset(input int r);
    @(negedge clk); #1;
    rst_n = 1'b0;
    req_wr = 1'b0; int_req = '0; ext_int = '0;
    m_st = 0; m_ib = 1'b0; m_pb = 1'b0;
    @(posedge clk); #1;
    push(r);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  // Monitor: compare each expectation at the falling edge after its push.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      obs_t e, g;
      int r;
      e = exp_q.pop_front();
      r = rid_q.pop_front();
      g = {idle_bit, pdown_bit, cpu_clk_en, per_clk_en, osc_en, ctl_ovr, ctl_lvl, port_mode};
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL R%0d got %b expected %b", r, g, e);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL R0 watchdog expired got hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hw_reset(1);                     // R1 reset state
    cyc(0, 0, 0, '0, '0, 1);         // R1 stays awake

    // internal program memory
    cyc(1, 1, 0, '0, '0, 2);         // R2 bit set, still running
    cyc(0, 0, 0, '0, '0, 2);         // R2 light sleep
    cyc(0, 0, 0, '0, '0, 8);         // R8 pins hold data
    cyc(0, 0, 0, 5'b01000, '0, 5);   // R5 wake on internal request
    cyc(0, 0, 0, '0, '0, 5);

    cyc(1, 0, 1, '0, '0, 3);         // R3 bit set
    cyc(0, 0, 0, '0, '0, 3);         // R3 deep sleep
    cyc(0, 0, 0, 5'b11111, '0, 6);   // R6 internal requests ignored
    cyc(1, 1, 0, '0, '0, 10);        // R10 write ignored
    cyc(0, 0, 0, '0, '0, 7);         // R7 deep strobe level
    cyc(0, 0, 0, '0, 2'b10, 6);      // R6 external wake

    cyc(1, 1, 1, '0, '0, 4);         // R4 both bits, deep wins
    cyc(0, 0, 0, '0, '0, 4);
    cyc(0, 0, 0, '0, 2'b01, 4);

    // external program memory
    ext_access = 1'b1;
    cyc(1, 1, 0, '0, '0, 9);
    cyc(0, 0, 0, '0, '0, 9);         // R9 light sleep pins
    cyc(0, 0, 0, '0, '0, 7);         // R7 light strobe level
    cyc(0, 0, 0, '0, 2'b01, 5);      // R5 wake on external request
    cyc(1, 0, 1, '0, '0, 9);
    cyc(0, 0, 0, '0, '0, 9);         // R9 deep sleep pins
    hw_reset(11);                    // R11 reset ends deep sleep
    cyc(1, 1, 0, '0, '0, 11);
    cyc(0, 0, 0, '0, '0, 11);
    hw_reset(11);                    // R11 reset ends light sleep
    cyc(0, 0, 0, '0, '0, 11);

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule